// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block owns the initialization bit and the bus-off flag of a CAN controller. When the error counter logic reports a bus-off event, the block sets the initialization bit by itself. While that bit is set, all bus activity stays stopped. Recovery starts only after software clears the bit. The block then watches the sampled bus level on every bit strobe and counts bus-idle occurrences. One occurrence is eleven consecutive recessive samples. It takes 129 such occurrences to return the controller to normal operation.

Each completed occurrence produces a one-cycle request to the status register to log the bit-0 error code. Software can use these requests to follow the progress of the recovery, or to see that the bus is stuck dominant. On the final occurrence the block drops the bus-off flag and requests a reset of the transmit and receive error counters. Software can pause the sequence by setting the initialization bit again, but it cannot shorten it.

Top module: `busoff_recovery`

## Requirements
- R1: When `busoff_evt` is high while `busoff` is low, `busoff` and `init_bit` are both 1 from the next clock edge on.
- R2: Occurrences are counted only while `busoff` is 1 and `init_bit` is 0. At all other times no `lec_wr` pulse is produced.
- R3: An occurrence is eleven consecutive recessive samples (`bus_rx` = 1) taken on cycles with `bit_tick` high. A dominant sample (`bus_rx` = 0) restarts the run at zero. Cycles without `bit_tick` are ignored. The run restarts after each occurrence, so 22 recessive samples give exactly two occurrences.
- R4: Each occurrence gives a one-cycle `lec_wr` pulse in the cycle after the completing sample, with `lec_code` = 3'b101 (the bit-0 code). `lec_code` is 3'b000 when `lec_wr` is low.
- R5: On the 129th occurrence, in the same cycle as its `lec_wr` pulse, `errcnt_clr` pulses high for exactly one cycle and `busoff` returns to 0, while `init_bit` stays 0.
- R6: Setting `init_bit` during recovery pauses counting and keeps the occurrence count already reached. After the bit is cleared, the total number of occurrences needed is still 129.
- R7: A partial recessive run is discarded whenever `init_bit` is set during recovery.
- R8: A `busoff_evt` while `busoff` is already 1 has no effect on `busoff`, on `init_bit` or on the occurrence count.
- R9: A synchronous active-high `rst` sets `init_bit`, `busoff`, `errcnt_clr`, `lec_wr` and `lec_code` to 0 and clears both counters.
- R10: A software write (`init_wr` high) loads `init_wdata` into `init_bit` at the next edge, unless R1 takes precedence in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe marking a valid bus sample |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| busoff_evt | input | 1 | Bus-off event from the error counter logic |
| init_wr | input | 1 | Software write strobe for the initialization bit |
| init_wdata | input | 1 | Value written to the initialization bit |
| init_bit | output | 1 | Current initialization bit |
| busoff | output | 1 | Bus-off status flag |
| errcnt_clr | output | 1 | One-cycle request to reset the TX and RX error counters |
| lec_wr | output | 1 | One-cycle request to write `lec_code` to the last-error-code field |
| lec_code | output | 3 | Code to log, 3'b101 when `lec_wr` is high |

## Verification
Every output is a register, so each result is due exactly one clock edge after the cycle that carries its cause. That cause is a strobed bus sample, a bus-off event or a software write. The bench drives each stimulus for one cycle starting at a falling edge, lowers it at the next falling edge, and samples the outputs at that same moment. This is just after the single edge that consumed the stimulus, so a one-cycle `lec_wr` or `errcnt_clr` pulse is seen exactly once. Pulses are tallied per bit. The completion check on the 129th occurrence is made on the sample right after the completing bit. A further sample one cycle later confirms that `errcnt_clr` has fallen.

// File: rtl/busoff_rec_pkg.sv
package busoff_rec_pkg;
  localparam int LEC_W = 3;
  localparam logic [LEC_W-1:0] LEC_BIT0 = 3'b101;
  localparam logic [LEC_W-1:0] LEC_NONE = 3'b000;
endpackage

// File: rtl/recessive_run_counter.sv
module recessive_run_counter #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic bit_tick,
  input  logic bus_rx,
  output logic run_done
);
  localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;

  assign run_done = enable && bit_tick && bus_rx && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt_q <= '0;
    end else if (bit_tick) begin
      if (!bus_rx || cnt_q == LAST) cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/idle_occurrence_counter.sv
module idle_occurrence_counter #(
  parameter int IDLE_COUNT = 129
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic last
);
  localparam int CW = (IDLE_COUNT > 1) ? $clog2(IDLE_COUNT) : 1;
  localparam logic [CW-1:0] FINAL = CW'(IDLE_COUNT - 1);

  logic [CW-1:0] occ_q;

  assign last = (occ_q == FINAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
    end else if (step) begin
      if (last) occ_q <= '0;
      else      occ_q <= occ_q + 1'b1;
    end
  end
endmodule

// File: rtl/busoff_recovery.sv
module busoff_recovery
  import busoff_rec_pkg::*;
#(
  parameter int RUN_LEN    = 11,
  parameter int IDLE_COUNT = 129
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             bus_rx,
  input  logic             busoff_evt,
  input  logic             init_wr,
  input  logic             init_wdata,
  output logic             init_bit,
  output logic             busoff,
  output logic             errcnt_clr,
  output logic             lec_wr,
  output logic [LEC_W-1:0] lec_code
);
  logic init_q, busoff_q, clr_q, lec_q;
  logic [LEC_W-1:0] code_q;
  logic count_en, run_done, occ_last;

  // counting only while bus-off and software has released init
  assign count_en = busoff_q && !init_q;

  recessive_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst      (rst),
    .enable   (count_en),
    .bit_tick (bit_tick),
    .bus_rx   (bus_rx),
    .run_done (run_done)
  );

  idle_occurrence_counter #(.IDLE_COUNT(IDLE_COUNT)) u_occ (
    .clk  (clk),
    .rst  (rst),
    .step (run_done),
    .last (occ_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q   <= 1'b0;
      busoff_q <= 1'b0;
      clr_q    <= 1'b0;
      lec_q    <= 1'b0;
      code_q   <= LEC_NONE;
    end else begin
      lec_q  <= run_done;
      code_q <= run_done ? LEC_BIT0 : LEC_NONE;
      clr_q  <= 1'b0;
      if (!busoff_q) begin
        if (busoff_evt) begin
          busoff_q <= 1'b1;
          init_q   <= 1'b1;
        end else if (init_wr) begin
          init_q <= init_wdata;
        end
      end else begin
        if (init_wr) init_q <= init_wdata;
        if (run_done && occ_last) begin
          busoff_q <= 1'b0;
          clr_q    <= 1'b1;
        end
      end
    end
  end

  assign init_bit   = init_q;
  assign busoff     = busoff_q;
  assign errcnt_clr = clr_q;
  assign lec_wr     = lec_q;
  assign lec_code   = code_q;
endmodule

// File: rtl/busoff_recovery_chk.sv
module busoff_recovery_chk #(
  parameter int IDLE_COUNT = 129
) (
  input logic       clk,
  input logic       rst,
  input logic       busoff_evt,
  input logic       init_bit,
  input logic       busoff,
  input logic       errcnt_clr,
  input logic       lec_wr,
  input logic [2:0] lec_code
);
  localparam int PW = $clog2(IDLE_COUNT + 1) + 1;
  logic [PW-1:0] pulses_q;

  always_ff @(posedge clk) begin
    if (rst)             pulses_q <= '0;
    else if (errcnt_clr) pulses_q <= '0;
    else if (lec_wr)     pulses_q <= pulses_q + 1'b1;
  end

  a_r1_busoff_sets_init: assert property (@(posedge clk) disable iff (rst)
    (!busoff && busoff_evt) |=> (busoff && init_bit));

  a_r2_no_count_when_init: assert property (@(posedge clk) disable iff (rst)
    init_bit |=> !lec_wr);

  a_r4_code_value: assert property (@(posedge clk) disable iff (rst)
    lec_wr |-> (lec_code == 3'b101));

  a_r4_code_idle: assert property (@(posedge clk) disable iff (rst)
    !lec_wr |-> (lec_code == 3'b000));

  a_r5_clr_ends_busoff: assert property (@(posedge clk) disable iff (rst)
    errcnt_clr |-> (!busoff && $past(busoff) && lec_wr && !init_bit));

  a_r5_fall_needs_clr: assert property (@(posedge clk) disable iff (rst)
    $fell(busoff) |-> errcnt_clr);

  a_r5_clr_single: assert property (@(posedge clk) disable iff (rst)
    errcnt_clr |=> !errcnt_clr);

  a_r6_full_count: assert property (@(posedge clk) disable iff (rst)
    errcnt_clr |-> (32'(pulses_q) + 1 == IDLE_COUNT));
endmodule

bind busoff_recovery busoff_recovery_chk #(.IDLE_COUNT(IDLE_COUNT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busoff_evt (busoff_evt),
  .init_bit   (init_bit),
  .busoff     (busoff),
  .errcnt_clr (errcnt_clr),
  .lec_wr     (lec_wr),
  .lec_code   (lec_code)
);

// File: tb/sim_busoff_recovery.sv
`timescale 1ns/1ps
module sim_busoff_recovery;
  logic clk = 1'b0;
  logic rst, bit_tick, bus_rx, busoff_evt, init_wr, init_wdata;
  logic init_bit, busoff, errcnt_clr, lec_wr;
  logic [2:0] lec_code;

  int n_chk = 0, n_bad = 0;
  int lec_seen = 0, clr_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  busoff_recovery u0 (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .bus_rx(bus_rx),
    .busoff_evt(busoff_evt), .init_wr(init_wr), .init_wdata(init_wdata),
    .init_bit(init_bit), .busoff(busoff), .errcnt_clr(errcnt_clr),
    .lec_wr(lec_wr), .lec_code(lec_code)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick_bit(logic lvl);
    @(negedge clk); bit_tick = 1'b1; bus_rx = lvl;
    @(negedge clk); bit_tick = 1'b0;
    if (lec_wr) begin
      lec_seen++;
      check("R4 lec_code on pulse", lec_code, 5);
    end
    if (errcnt_clr) clr_seen++;
  endtask

  task automatic feed(int n, logic lvl);
    for (int i = 0; i < n; i++) tick_bit(lvl);
  endtask

  task automatic write_init(logic v);
    @(negedge clk); init_wr = 1'b1; init_wdata = v;
    @(negedge clk); init_wr = 1'b0;
  endtask

  task automatic pulse_evt();
    @(negedge clk); busoff_evt = 1'b1;
    @(negedge clk); busoff_evt = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; bit_tick = 0; bus_rx = 1; busoff_evt = 0; init_wr = 0; init_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 init_bit", init_bit, 0);
    check("R9 busoff", busoff, 0);
    check("R9 errcnt_clr", errcnt_clr, 0);
    check("R9 lec_wr", lec_wr, 0);
    check("R9 lec_code", lec_code, 0);
  endtask

  task automatic t_normal();
    write_init(1'b1);
    check("R10 init set by write", init_bit, 1);
    write_init(1'b0);
    check("R10 init cleared by write", init_bit, 0);
    lec_seen = 0;
    feed(30, 1'b1);
    check("R2 no count in normal mode", lec_seen, 0);
  endtask

  task automatic t_enter();
    pulse_evt();
    check("R1 busoff set", busoff, 1);
    check("R1 init set", init_bit, 1);
    feed(25, 1'b1);
    check("R2 no count while init held", lec_seen, 0);
  endtask

  task automatic t_runs();
    write_init(1'b0);
    feed(10, 1'b1); feed(1, 1'b0); feed(10, 1'b1);
    check("R3 dominant restarts run", lec_seen, 0);
    feed(1, 1'b1);
    check("R3 eleventh recessive completes", lec_seen, 1);
    feed(5, 1'b1);
    @(negedge clk); bus_rx = 1'b0;
    repeat (3) @(negedge clk);
    feed(5, 1'b1);
    check("R3 untimed samples ignored (partial)", lec_seen, 1);
    feed(1, 1'b1);
    check("R3 untimed samples ignored", lec_seen, 2);
    feed(22, 1'b1);
    check("R3 runs do not overlap", lec_seen, 4);
    check("R4 busoff kept during recovery", busoff, 1);
  endtask

  task automatic t_pause();
    feed(7, 1'b1);
    write_init(1'b1);
    feed(20, 1'b1);
    check("R6 paused while init set", lec_seen, 4);
    pulse_evt();
    check("R8 busoff unchanged by event", busoff, 1);
    check("R8 init unchanged by event", init_bit, 1);
    write_init(1'b0);
    feed(4, 1'b1);
    check("R7 partial run discarded", lec_seen, 4);
    feed(7, 1'b1);
    check("R6 counting resumes", lec_seen, 5);
  endtask

  task automatic t_finish();
    feed(11 * 123, 1'b1);
    check("R6 128 occurrences counted", lec_seen, 128);
    check("R6 still bus-off after 128", busoff, 1);
    check("R6 no clear before 129", clr_seen, 0);
    feed(10, 1'b1);
    @(negedge clk); bit_tick = 1'b1; bus_rx = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
    check("R5 lec_wr on final", lec_wr, 1);
    check("R5 errcnt_clr on final", errcnt_clr, 1);
    check("R5 busoff cleared", busoff, 0);
    check("R5 init stays clear", init_bit, 0);
    @(negedge clk);
    check("R5 errcnt_clr single cycle", errcnt_clr, 0);
    lec_seen = 0; clr_seen = 0;
    feed(22, 1'b1);
    check("R2 no count after recovery", lec_seen, 0);
    check("R5 no extra clear", clr_seen, 0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_enter();
    t_runs();
    t_pause();
    t_finish();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule